// File: doc/BRIEF.md
# Look-Ahead XY Route Computation Unit

This unit computes routes for one input of a router in a 2D mesh. Each header flit arrives with the output direction it must take at this node, because the neighbour that sent it already worked that out. The unit finds the neighbour the flit will enter next by stepping the node's own coordinates one hop in that direction. It then applies dimension-ordered routing (X first, then Y) from that neighbour to the destination. Both the current-node direction and the next-hop direction are registered and attached to the flit. The unit also derives three flags from them:
- which half of the next router (the row or the column switch) will queue the flit;
- whether the flit changes dimension at that point;
- whether the flit leaves the network here (early ejection).

When the neighbour that sent a header has reported a failed route unit, the carried direction cannot be trusted. The unit then routes twice. It first computes the current-node direction from its own coordinates, and in the following cycle it computes the look-ahead direction. Body and tail flits reuse the route of their header. The unit also passes its own route-unit failure indication to its neighbours as a registered status bit.

Top module: `lar_route_unit`

## Requirements
- R1: While reset is high and in the cycle after it, `o_vld` and `o_fault` are 0.
- R2: A header flit (`i_vld`=1, `i_head`=1) that arrives from a neighbour whose fault bit is clear appears one cycle later with `o_vld`=1 and `o_head`=1. Its `o_cur` equals the carried `i_route`. Direction encoding: 0 local, 1 east (x+1), 2 west (x-1), 3 north (y+1), 4 south (y-1).
- R3: `o_nxt` is the XY route from the node reached by stepping one hop in direction `o_cur` to the destination. It is 0 when that node is the destination.
- R4: Routing is X first. A non-zero X offset gives east or west; only a zero X offset gives north or south.
- R5: If `i_nbr_fault` has the bit of the arrival port set, the carried route is ignored. Bit map: bit0 east, bit1 west, bit2 north, bit3 south; port encoding as in R2. In that case `o_cur` is the XY route from the own coordinates, `o_vld` stays 0 in the first cycle, and the result appears in the second cycle.
- R6: Fault bits of ports other than the arrival port have no effect: the header takes the one-cycle path.
- R7: When `o_cur` is local, `o_eject`=1 and `o_nxt`=0.
- R8: `o_col` is 1 exactly when `o_nxt` is north or south.
- R9: `o_turn` is 1 exactly when `o_cur` and `o_nxt` lie in different dimensions, neither of them local.
- R10: A non-header flit appears one cycle later with `o_vld`=1 and `o_head`=0, and `o_tail` equals `i_tail`. `o_cur` and `o_nxt` keep the values of the packet's header.
- R11: `o_fault` equals `i_rc_fail` delayed by one cycle.
- R12: A cycle with no input flit and no pending double route gives `o_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_vld | input | 1 | Flit present |
| i_head | input | 1 | Flit is a header |
| i_tail | input | 1 | Flit is the last of its packet |
| i_port | input | 3 | Arrival port (direction encoding) |
| i_route | input | 3 | Direction carried by the flit for this node |
| i_dst_x | input | CW | Destination X |
| i_dst_y | input | CW | Destination Y |
| i_own_x | input | CW | This node's X |
| i_own_y | input | CW | This node's Y |
| i_nbr_fault | input | 4 | Route-unit failure bits of the four neighbours |
| i_rc_fail | input | 1 | This node's route unit has failed |
| o_vld | output | 1 | Result valid |
| o_head | output | 1 | Result belongs to a header |
| o_tail | output | 1 | Result belongs to a tail flit |
| o_cur | output | 3 | Direction at this node |
| o_nxt | output | 3 | Direction at the next node |
| o_col | output | 1 | Next router queues the flit in its column switch |
| o_turn | output | 1 | Flit changes dimension at the next hop |
| o_eject | output | 1 | Flit is ejected at this node |
| o_fault | output | 1 | Registered failure status for the neighbours |

## Verification
The checks assume that no flit arrives in the cycle after a header that triggered double routing. The bench always leaves that cycle idle, and an input check flags any violation. The checks also assume that carried routes and destinations agree with XY routing inside the mesh, so a flit that moves north or south never has an east or west next hop. Every vector in the table is built from such consistent coordinates. Local injections always carry a route, so they never take the double-routing path.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int DIRW = 3;
  localparam logic [DIRW-1:0] DIR_L = 3'd0;
  localparam logic [DIRW-1:0] DIR_E = 3'd1;
  localparam logic [DIRW-1:0] DIR_W = 3'd2;
  localparam logic [DIRW-1:0] DIR_N = 3'd3;
  localparam logic [DIRW-1:0] DIR_S = 3'd4;
  localparam int NNBR = 4;

  function automatic logic is_xdir(input logic [DIRW-1:0] d);
    return (d == DIR_E) || (d == DIR_W);
  endfunction

  function automatic logic is_ydir(input logic [DIRW-1:0] d);
    return (d == DIR_N) || (d == DIR_S);
  endfunction
endpackage

// File: rtl/lar_xy.sv
module lar_xy #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  output logic [2:0]    dir
);
  import lar_pkg::*;
  always_comb begin
    if (dx > cx)      dir = DIR_E;
    else if (dx < cx) dir = DIR_W;
    else if (dy > cy) dir = DIR_N;
    else if (dy < cy) dir = DIR_S;
    else              dir = DIR_L;
  end
endmodule

// File: rtl/lar_step.sv
module lar_step #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] cx,
  input  logic [CW-1:0] cy,
  input  logic [2:0]    dir,
  output logic [CW-1:0] nx,
  output logic [CW-1:0] ny
);
  import lar_pkg::*;
  localparam logic [CW-1:0] ONE = CW'(1);
  always_comb begin
    nx = cx;
    ny = cy;
    case (dir)
      DIR_E:   nx = cx + ONE;
      DIR_W:   nx = cx - ONE;
      DIR_N:   ny = cy + ONE;
      DIR_S:   ny = cy - ONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/lar_route_unit.sv
module lar_route_unit #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_vld,
  input  logic          i_head,
  input  logic          i_tail,
  input  logic [2:0]    i_port,
  input  logic [2:0]    i_route,
  input  logic [CW-1:0] i_dst_x,
  input  logic [CW-1:0] i_dst_y,
  input  logic [CW-1:0] i_own_x,
  input  logic [CW-1:0] i_own_y,
  input  logic [3:0]    i_nbr_fault,
  input  logic          i_rc_fail,
  output logic          o_vld,
  output logic          o_head,
  output logic          o_tail,
  output logic [2:0]    o_cur,
  output logic [2:0]    o_nxt,
  output logic          o_col,
  output logic          o_turn,
  output logic          o_eject,
  output logic          o_fault
);
  import lar_pkg::*;

  // arrival-port fault decode
  logic [NNBR-1:0] hit;
  genvar g;
  generate
    for (g = 0; g < NNBR; g++) begin : g_hit
      assign hit[g] = i_nbr_fault[g] && (i_port == 3'(g + 1));
    end
  endgenerate
  logic fb_hit;
  assign fb_hit = |hit;

  // pending double-route state
  logic          pend_q;
  logic          pend_tail_q;
  logic [2:0]    pend_cur_q;
  logic [CW-1:0] pend_dx_q, pend_dy_q;

  logic [2:0]    sel_cur;
  logic [CW-1:0] sel_dx, sel_dy;
  assign sel_cur = pend_q ? pend_cur_q : i_route;
  assign sel_dx  = pend_q ? pend_dx_q  : i_dst_x;
  assign sel_dy  = pend_q ? pend_dy_q  : i_dst_y;

  logic [2:0]    here_dir, ahead_dir;
  logic [CW-1:0] step_x, step_y;

  lar_xy #(.CW(CW)) u_here (
    .cx(i_own_x), .cy(i_own_y), .dx(i_dst_x), .dy(i_dst_y), .dir(here_dir));

  lar_step #(.CW(CW)) u_step (
    .cx(i_own_x), .cy(i_own_y), .dir(sel_cur), .nx(step_x), .ny(step_y));

  lar_xy #(.CW(CW)) u_ahead (
    .cx(step_x), .cy(step_y), .dx(sel_dx), .dy(sel_dy), .dir(ahead_dir));

  logic [2:0] nxt_w;
  logic       col_w, turn_w, eject_w;
  always_comb begin
    eject_w = (sel_cur == DIR_L);
    nxt_w   = eject_w ? DIR_L : ahead_dir;
    col_w   = is_ydir(nxt_w);
    turn_w  = (is_xdir(sel_cur) && is_ydir(nxt_w)) ||
              (is_ydir(sel_cur) && is_xdir(nxt_w));
  end

  logic acc_fb, acc_hd, acc_bd;
  assign acc_fb = i_vld && i_head && fb_hit;
  assign acc_hd = i_vld && i_head && !fb_hit;
  assign acc_bd = i_vld && !i_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld       <= 1'b0;
      o_head      <= 1'b0;
      o_tail      <= 1'b0;
      o_cur       <= DIR_L;
      o_nxt       <= DIR_L;
      o_col       <= 1'b0;
      o_turn      <= 1'b0;
      o_eject     <= 1'b0;
      o_fault     <= 1'b0;
      pend_q      <= 1'b0;
      pend_tail_q <= 1'b0;
      pend_cur_q  <= DIR_L;
      pend_dx_q   <= '0;
      pend_dy_q   <= '0;
    end else begin
      o_fault <= i_rc_fail;
      o_vld   <= 1'b0;
      if (pend_q) begin
        pend_q  <= 1'b0;
        o_vld   <= 1'b1;
        o_head  <= 1'b1;
        o_tail  <= pend_tail_q;
        o_cur   <= pend_cur_q;
        o_nxt   <= nxt_w;
        o_col   <= col_w;
        o_turn  <= turn_w;
        o_eject <= eject_w;
      end else if (acc_fb) begin
        pend_q      <= 1'b1;
        pend_tail_q <= i_tail;
        pend_cur_q  <= here_dir;
        pend_dx_q   <= i_dst_x;
        pend_dy_q   <= i_dst_y;
      end else if (acc_hd) begin
        o_vld   <= 1'b1;
        o_head  <= 1'b1;
        o_tail  <= i_tail;
        o_cur   <= i_route;
        o_nxt   <= nxt_w;
        o_col   <= col_w;
        o_turn  <= turn_w;
        o_eject <= eject_w;
      end else if (acc_bd) begin
        o_vld  <= 1'b1;
        o_head <= 1'b0;
        o_tail <= i_tail;
      end
    end
  end

  // R2
  head_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && acc_hd) |=> (o_vld && o_head && o_cur == $past(i_route)));

  // R5
  fb_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && acc_fb) |=> (!o_vld ##1 (o_vld && o_head)));

  // R5
  fb_idle_in_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !i_vld);

  // R10
  body_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && acc_bd) |=> (o_vld && !o_head && $stable(o_cur) && $stable(o_nxt)));

  // R11
  fault_dly_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (o_fault == $past(i_rc_fail)));

  // R4
  no_yx_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (o_vld && o_head && is_ydir(o_cur)) |-> !is_xdir(o_nxt));
endmodule

// File: tb/lar_route_unit_tb.sv
module lar_route_unit_tb;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst;
  logic i_vld, i_head, i_tail, i_rc_fail;
  logic [2:0] i_port, i_route;
  logic [CW-1:0] i_dst_x, i_dst_y, i_own_x, i_own_y;
  logic [3:0] i_nbr_fault;
  logic o_vld, o_head, o_tail, o_col, o_turn, o_eject, o_fault;
  logic [2:0] o_cur, o_nxt;

  always #10 clk = ~clk;

  lar_route_unit #(.CW(CW)) u_dut (
    .clk(clk), .rst(rst), .i_vld(i_vld), .i_head(i_head), .i_tail(i_tail),
    .i_port(i_port), .i_route(i_route), .i_dst_x(i_dst_x), .i_dst_y(i_dst_y),
    .i_own_x(i_own_x), .i_own_y(i_own_y), .i_nbr_fault(i_nbr_fault),
    .i_rc_fail(i_rc_fail), .o_vld(o_vld), .o_head(o_head), .o_tail(o_tail),
    .o_cur(o_cur), .o_nxt(o_nxt), .o_col(o_col), .o_turn(o_turn),
    .o_eject(o_eject), .o_fault(o_fault));

  typedef struct packed {
    int ox; int oy; int dx; int dy; int port; int la; int fmask; int ecur; int enxt;
  } vec_t;

  // own, dest, arrival port, carried route, fault mask, expected cur, expected nxt
  localparam vec_t VEC [12] = '{
    '{2,2,5,4,2,1,0,1,1},
    '{2,2,3,4,2,1,0,1,3},
    '{2,2,2,0,3,4,0,4,4},
    '{2,2,2,2,1,0,0,0,0},
    '{2,2,1,2,1,2,0,2,0},
    '{2,2,0,5,0,2,0,2,2},
    '{2,2,4,2,2,1,4,1,1},
    '{2,2,2,5,4,1,8,3,3},
    '{3,1,0,3,1,4,1,2,2},
    '{3,1,4,1,2,3,2,1,0},
    '{3,1,3,1,3,1,4,0,0},
    '{0,0,1,3,2,0,15,1,3}
  };

  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ydim(input int d);
    return (d == 3 || d == 4) ? 1 : 0;
  endfunction
  function automatic int xdim(input int d);
    return (d == 1 || d == 2) ? 1 : 0;
  endfunction

  task automatic run_vec(input vec_t v);
    bit fb;
    string rq;
    fb = (v.port != 0) && v.fmask[v.port-1];
    rq = fb ? "R5" : ((v.fmask != 0) ? "R6" : "R2");
    i_own_x = v.ox[CW-1:0]; i_own_y = v.oy[CW-1:0];
    i_dst_x = v.dx[CW-1:0]; i_dst_y = v.dy[CW-1:0];
    i_port = v.port[2:0]; i_route = v.la[2:0];
    i_nbr_fault = v.fmask[3:0];
    i_vld = 1'b1; i_head = 1'b1; i_tail = 1'b0;
    @(negedge clk);
    i_vld = 1'b0;
    if (fb) begin
      chk("R5 gap vld", int'(o_vld), 0);
      @(negedge clk);
    end
    chk({rq, " vld"}, int'(o_vld), 1);
    chk({rq, " head"}, int'(o_head), 1);
    chk({rq, " cur"}, int'(o_cur), v.ecur);
    chk("R3 R4 nxt", int'(o_nxt), v.enxt);
    chk("R7 eject", int'(o_eject), (v.ecur == 0) ? 1 : 0);
    chk("R8 col", int'(o_col), ydim(v.enxt));
    chk("R9 turn", int'(o_turn),
        ((xdim(v.ecur) && ydim(v.enxt)) || (ydim(v.ecur) && xdim(v.enxt))) ? 1 : 0);
    i_nbr_fault = 4'd0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; i_vld = 1'b0; i_head = 1'b0; i_tail = 1'b0; i_rc_fail = 1'b1;
    i_port = 3'd0; i_route = 3'd0; i_dst_x = '0; i_dst_y = '0;
    i_own_x = '0; i_own_y = '0; i_nbr_fault = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", int'(o_vld), 0);
    chk("R1 fault in reset", int'(o_fault), 0);
    rst = 1'b0; i_rc_fail = 1'b0;
    @(negedge clk);
    chk("R1 vld after reset", int'(o_vld), 0);
    chk("R1 fault after reset", int'(o_fault), 0);

    for (int k = 0; k < 12; k++) begin
      run_vec(VEC[k]);
    end

    // body flits hold header route
    run_vec(VEC[1]);
    i_vld = 1'b1; i_head = 1'b0; i_tail = 1'b0; i_route = 3'd4;
    i_dst_x = 4'd0; i_dst_y = 4'd0;
    @(negedge clk);
    chk("R10 body vld", int'(o_vld), 1);
    chk("R10 body head", int'(o_head), 0);
    chk("R10 body tail", int'(o_tail), 0);
    chk("R10 body cur", int'(o_cur), 1);
    chk("R10 body nxt", int'(o_nxt), 3);
    i_tail = 1'b1;
    @(negedge clk);
    i_vld = 1'b0; i_tail = 1'b0;
    chk("R10 tail flag", int'(o_tail), 1);
    chk("R10 tail cur", int'(o_cur), 1);
    @(negedge clk);
    chk("R12 idle", int'(o_vld), 0);

    // fallback header that is also the tail
    i_own_x = 4'd1; i_own_y = 4'd1; i_dst_x = 4'd1; i_dst_y = 4'd4;
    i_port = 3'd1; i_route = 3'd2; i_nbr_fault = 4'd1;
    i_vld = 1'b1; i_head = 1'b1; i_tail = 1'b1;
    @(negedge clk);
    i_vld = 1'b0; i_tail = 1'b0; i_nbr_fault = 4'd0;
    chk("R5 single gap", int'(o_vld), 0);
    @(negedge clk);
    chk("R5 single tail", int'(o_tail), 1);
    chk("R5 single cur", int'(o_cur), 3);
    chk("R3 single nxt", int'(o_nxt), 3);

    // fault status
    i_rc_fail = 1'b1;
    @(negedge clk);
    chk("R11 fault rise", int'(o_fault), 1);
    i_rc_fail = 1'b0;
    @(negedge clk);
    chk("R11 fault fall", int'(o_fault), 0);
    chk("R12 idle end", int'(o_vld), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule